// File: doc/BRIEF.md
# Decimating LFSR Keystream Generator

This block produces the keystream for a bitwise stream cipher. Two linear feedback shift registers are programmed at run time, each with its own length, feedback taps and seed. A mode bit chooses between two ways of thinning the register output. In pair mode, a selector register decides for each step whether the bit leaving a data register is kept or thrown away. In single mode, one register supplies both the decision bit and the data bit, and it moves two positions per decision.

The number of kept bits per step varies, so kept bits are collected in a small bit queue. A consumer takes one keystream bit per beat through a valid/ready handshake. On the same beat the block returns the consumer's data bit XORed with that keystream bit, which serves for both encryption and decryption. The generator pauses whenever the queue is full, so no kept bit is ever lost. The generator clock is meant to run well above the consumer's bit rate.

Top module: `shrink_keygen`

## Requirements
- R1: Pair mode (`cfg_self`=0): on every generator step both registers advance by one position. The data register's output bit is queued only when the selector register's output bit is 1.
- R2: Single mode (`cfg_self`=1): on every step the data register's bit at index L-1 is the decision bit and its bit at index L-2 is the candidate. The candidate is queued when the decision bit is 1, and the register then advances two positions. The selector register is not used in this mode.
- R3: A length value below 7 acts as 7 and a value above 65 acts as 65. Seed and tap bits at index L or above are ignored.
- R4: A register of length L holding state s advances to {s[L-2:0], f}, where f is the XOR of s[i]&tap[i] over i<L. Its output bit is s[L-1].
- R5: A seed that is zero after masking loads as 1, with only bit 0 set, and sets the sticky flag `seed_warn`. The selector seed is only checked in pair mode. The flag is cleared only by reset.
- R6: Kept bits leave in the order they were produced. The generator stalls while the queue holds FIFO_DEPTH bits and resumes without losing any bit.
- R7: `ks_valid` is high exactly when the queue is non-empty. A bit is removed on a cycle where both `ks_valid` and `ks_ready` are high.
- R8: `enc_out` equals `data_in` XOR `ks_bit` on the beat that bit is delivered.
- R9: `ks_ready` high while the queue is empty sets the sticky flag `miss`, which only reset clears.
- R10: No bit is produced before the first `cfg_load`. A `cfg_load` empties the queue and restarts generation from the new seeds on the following cycle.
- R11: After reset, `ks_valid`, `seed_warn` and `miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that loads every cfg_* value |
| cfg_self | input | 1 | 1 = single-register mode, 0 = pair mode |
| cfg_sel_len | input | 7 | Selector register length |
| cfg_sel_taps | input | 65 | Selector feedback tap mask |
| cfg_sel_seed | input | 65 | Selector initial state |
| cfg_gen_len | input | 7 | Data register length |
| cfg_gen_taps | input | 65 | Data register tap mask |
| cfg_gen_seed | input | 65 | Data register initial state |
| ks_ready | input | 1 | Consumer requests a keystream bit |
| data_in | input | 1 | Data bit to combine with the keystream |
| ks_valid | output | 1 | A keystream bit is available |
| ks_bit | output | 1 | Head keystream bit |
| enc_out | output | 1 | data_in XOR ks_bit |
| seed_warn | output | 1 | Sticky: a zero seed was corrected |
| miss | output | 1 | Sticky: request made while empty |

## Verification
A wrong tap mask, length decode or step count inside either register does not show up as a flag. It shows up in the keystream itself, usually within a handful of delivered bits, because one wrong feedback bit moves the sequence onto a different trajectory. A queue that drops or repeats a bit is seen as a shifted stream from the first affected beat onward. For that reason the bench holds the consumer back for long stretches, so that the full queue and the stalled generator are part of the compared stream. The sticky flags are observed the cycle after the triggering load or request.

// File: rtl/shrink_pkg.sv
package shrink_pkg;
    localparam int unsigned MAX_LEN = 65;
    localparam int unsigned MIN_LEN = 7;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    typedef logic [MAX_LEN-1:0] lfsr_vec_t;
    typedef logic [LEN_W-1:0]   len_t;

    typedef enum logic {
        MODE_PAIR = 1'b0,
        MODE_SELF = 1'b1
    } sk_mode_e;

    typedef struct packed {
        len_t      len;
        lfsr_vec_t taps;
        lfsr_vec_t seed;
    } reg_cfg_t;

    function automatic len_t clamp_len(input len_t l);
        if (l < len_t'(MIN_LEN)) return len_t'(MIN_LEN);
        if (l > len_t'(MAX_LEN)) return len_t'(MAX_LEN);
        return l;
    endfunction

    function automatic lfsr_vec_t len_mask(input len_t l);
        lfsr_vec_t m;
        for (int i = 0; i < MAX_LEN; i++) m[i] = (i < int'(l));
        return m;
    endfunction

    function automatic lfsr_vec_t lfsr_adv(input lfsr_vec_t s, input lfsr_vec_t taps,
                                           input lfsr_vec_t mask);
        logic fb;
        fb = ^(s & taps);
        return {s[MAX_LEN-2:0], fb} & mask;
    endfunction
endpackage

// File: rtl/sk_lfsr.sv
module sk_lfsr
    import shrink_pkg::*;
#(
    parameter int unsigned HEAD_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  reg_cfg_t          cfg,
    input  logic              adv,
    input  logic              dbl,
    output logic [HEAD_W-1:0] head,
    output logic              seed_zero
);
    lfsr_vec_t state_q, taps_q, mask_q;
    len_t      len_q;
    len_t      len_c;
    lfsr_vec_t mask_c, seed_m, one_step;

    assign len_c     = clamp_len(cfg.len);
    assign mask_c    = len_mask(len_c);
    assign seed_m    = cfg.seed & mask_c;
    assign seed_zero = (seed_m == '0);
    assign one_step  = lfsr_adv(state_q, taps_q, mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            taps_q  <= '0;
            mask_q  <= '0;
            len_q   <= len_t'(MIN_LEN);
        end else if (load) begin
            state_q <= seed_zero ? lfsr_vec_t'(1) : seed_m;
            taps_q  <= cfg.taps & mask_c;
            mask_q  <= mask_c;
            len_q   <= len_c;
        end else if (adv) begin
            state_q <= dbl ? lfsr_adv(one_step, taps_q, mask_q) : one_step;
        end
    end

    assign head[0] = state_q[len_q - len_t'(1)];
    generate
        if (HEAD_W > 1) begin : g_second
            assign head[1] = state_q[len_q - len_t'(2)];
        end
    endgenerate

    // R5: a freshly loaded state is never all-zero
    p_seed_fix_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(load) && !$past(rst)) |-> (state_q != '0));
    // R3: no state bit at or above the programmed length is ever set
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_q & ~mask_q) == '0));
endmodule

// File: rtl/sk_bitq.sv
module sk_bitq #(
    parameter int unsigned DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic push,
    input  logic din,
    input  logic pop,
    output logic dout,
    output logic empty,
    output logic full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= din;
    end

    // R6: the producer never pushes into a full queue
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R7: a pop never hits an empty queue
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R6: occupancy stays within the depth
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/shrink_keygen.sv
module shrink_keygen
    import shrink_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic               cfg_self,
    input  logic [LEN_W-1:0]   cfg_sel_len,
    input  logic [MAX_LEN-1:0] cfg_sel_taps,
    input  logic [MAX_LEN-1:0] cfg_sel_seed,
    input  logic [LEN_W-1:0]   cfg_gen_len,
    input  logic [MAX_LEN-1:0] cfg_gen_taps,
    input  logic [MAX_LEN-1:0] cfg_gen_seed,
    input  logic               ks_ready,
    input  logic               data_in,
    output logic               ks_valid,
    output logic               ks_bit,
    output logic               enc_out,
    output logic               seed_warn,
    output logic               miss
);
    sk_mode_e mode_q, mode_in;
    logic     cfg_ok_q, warn_q, miss_q;
    reg_cfg_t sel_cfg, gen_cfg;
    logic     sel_head;
    logic [1:0] gen_head;
    logic     sel_zero, gen_zero;
    logic     run, push, cand, q_empty, q_full, pop;

    assign mode_in = sk_mode_e'(cfg_self);
    assign sel_cfg = '{len: cfg_sel_len, taps: cfg_sel_taps, seed: cfg_sel_seed};
    assign gen_cfg = '{len: cfg_gen_len, taps: cfg_gen_taps, seed: cfg_gen_seed};

    assign run = cfg_ok_q && !q_full && !cfg_load;

    sk_lfsr #(.HEAD_W(1)) u_sel (
        .clk(clk), .rst(rst), .load(cfg_load), .cfg(sel_cfg),
        .adv(run && (mode_q == MODE_PAIR)), .dbl(1'b0),
        .head(sel_head), .seed_zero(sel_zero)
    );

    sk_lfsr #(.HEAD_W(2)) u_gen (
        .clk(clk), .rst(rst), .load(cfg_load), .cfg(gen_cfg),
        .adv(run), .dbl(mode_q == MODE_SELF),
        .head(gen_head), .seed_zero(gen_zero)
    );

    always_comb begin
        if (mode_q == MODE_SELF) begin
            push = run && gen_head[0];
            cand = gen_head[1];
        end else begin
            push = run && sel_head;
            cand = gen_head[0];
        end
    end

    assign pop = ks_valid && ks_ready;

    sk_bitq #(.DEPTH(FIFO_DEPTH)) u_q (
        .clk(clk), .rst(rst), .flush(cfg_load),
        .push(push), .din(cand), .pop(pop),
        .dout(ks_bit), .empty(q_empty), .full(q_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_PAIR;
            cfg_ok_q <= 1'b0;
            warn_q   <= 1'b0;
            miss_q   <= 1'b0;
        end else begin
            if (cfg_load) begin
                mode_q   <= mode_in;
                cfg_ok_q <= 1'b1;
                if (gen_zero || ((mode_in == MODE_PAIR) && sel_zero)) warn_q <= 1'b1;
            end
            if (ks_ready && q_empty) miss_q <= 1'b1;
        end
    end

    assign ks_valid  = !q_empty;
    assign enc_out   = data_in ^ ks_bit;
    assign seed_warn = warn_q;
    assign miss      = miss_q;

    // R9: miss stays set once raised
    p_miss_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        miss |=> miss);
    // R5: warning stays set once raised
    p_warn_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        seed_warn |=> seed_warn);
    // R10: nothing is offered before the first configuration
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok_q |-> !ks_valid);
    // R10: a configuration load leaves the queue empty
    p_flush_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_load) && !$past(rst)) |-> !ks_valid);
endmodule

// File: tb/shrink_keygen_tb.sv
module shrink_keygen_tb;
    localparam int CLK_P = 10;
    localparam int ML = 65;

    logic clk = 0, rst = 1;
    logic cfg_load = 0, cfg_self = 0;
    logic [6:0] cfg_sel_len = 7, cfg_gen_len = 7;
    logic [ML-1:0] cfg_sel_taps = '0, cfg_sel_seed = '0, cfg_gen_taps = '0, cfg_gen_seed = '0;
    logic ks_ready = 0, data_in = 0;
    logic ks_valid, ks_bit, enc_out, seed_warn, miss;

    int checks = 0, errors = 0, cyc = 0;
    bit exp_q[$];

    shrink_keygen u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_self(cfg_self),
        .cfg_sel_len(cfg_sel_len), .cfg_sel_taps(cfg_sel_taps), .cfg_sel_seed(cfg_sel_seed),
        .cfg_gen_len(cfg_gen_len), .cfg_gen_taps(cfg_gen_taps), .cfg_gen_seed(cfg_gen_seed),
        .ks_ready(ks_ready), .data_in(data_in), .ks_valid(ks_valid), .ks_bit(ks_bit),
        .enc_out(enc_out), .seed_warn(seed_warn), .miss(miss)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model, written from the requirements
    function automatic int clampl(input int l);
        if (l < 7) return 7;
        if (l > 65) return 65;
        return l;
    endfunction

    function automatic bit [ML-1:0] mstep(input bit [ML-1:0] s, input bit [ML-1:0] t, input int l);
        bit f = 0;
        bit [ML-1:0] n = '0;
        for (int i = 0; i < l; i++) f ^= s[i] & t[i];
        for (int i = l - 1; i > 0; i--) n[i] = s[i-1];
        n[0] = f;
        return n;
    endfunction

    function automatic bit [ML-1:0] mload(input bit [ML-1:0] s, input int l);
        bit [ML-1:0] r = '0;
        for (int i = 0; i < l; i++) r[i] = s[i];
        if (r == '0) r[0] = 1'b1;
        return r;
    endfunction

    task automatic load_cfg(input bit self_m, input int ls, input bit [ML-1:0] ts, input bit [ML-1:0] ss,
                            input int lg, input bit [ML-1:0] tg, input bit [ML-1:0] sg, input int n);
        bit [ML-1:0] a, b;
        int la, lb, got;
        @(negedge clk);
        cfg_self = self_m;
        cfg_sel_len = 7'(ls); cfg_sel_taps = ts; cfg_sel_seed = ss;
        cfg_gen_len = 7'(lg); cfg_gen_taps = tg; cfg_gen_seed = sg;
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
        exp_q.delete();
        la = clampl(ls); lb = clampl(lg);
        a = mload(ss, la); b = mload(sg, lb);
        got = 0;
        while (got < n) begin
            if (self_m) begin
                bit d = b[lb-1], c = b[lb-2];
                b = mstep(mstep(b, tg, lb), tg, lb);
                if (d) begin exp_q.push_back(c); got++; end
            end else begin
                bit d = a[la-1], c = b[lb-1];
                a = mstep(a, ts, la);
                b = mstep(b, tg, lb);
                if (d) begin exp_q.push_back(c); got++; end
            end
        end
    endtask

    // monitor: pulls n bits and compares against the scoreboard queue
    task automatic consume(input int n, input string tag);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            ks_ready = 0;
            if (ks_valid) begin
                bit d = 1'($urandom);
                bit e = exp_q.pop_front();
                data_in = d;
                ks_ready = 1;
                #1;
                check(ks_bit == e, tag, ks_bit, e);
                check(enc_out == (d ^ e), {tag, " R8 enc_out"}, enc_out, d ^ e);
                got++;
            end
        end
        @(negedge clk);
        ks_ready = 0;
    endtask

    localparam bit [ML-1:0] T7  = 65'h60;
    localparam bit [ML-1:0] T11 = 65'h500;
    localparam bit [ML-1:0] T17 = 65'h12000;
    localparam bit [ML-1:0] T65 = 65'h1_0000_4000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        check(ks_valid == 0, "R11 ks_valid", ks_valid, 0);
        check(seed_warn == 0, "R11 seed_warn", seed_warn, 0);
        check(miss == 0, "R11 miss", miss, 0);
        // R10: nothing before configuration
        repeat (5) @(negedge clk);
        check(ks_valid == 0, "R10 no output before load", ks_valid, 0);
        // R9: request while empty
        ks_ready = 1;
        @(negedge clk);
        ks_ready = 0;
        check(miss == 1, "R9 miss set", miss, 1);
        @(negedge clk);
        check(miss == 1, "R9 miss sticky", miss, 1);
        rst = 1; @(negedge clk); rst = 0;
        check(miss == 0, "R11 miss cleared by reset", miss, 0);

        // R1/R4: pair mode, short lengths
        load_cfg(0, 7, T7, 65'h5A, 11, T11, 65'h3C1, 48);
        check(ks_valid == 0, "R10 empty right after load", ks_valid, 0);
        consume(48, "R1 pair 7/11");

        // R2: single mode, selector seed zero must not warn
        load_cfg(1, 7, T7, 65'h0, 17, T17, 65'h1ACE1, 48);
        check(seed_warn == 0, "R5 unused selector seed ignored", seed_warn, 0);
        consume(48, "R2 single 17");

        // R3: length clamps and out-of-range tap/seed bits
        load_cfg(0, 3, T7 | 65'hF00, 65'hFFFF_FFFF_FFFF_FF11, 100, T65, 65'h1_2345_6789_ABCD_EF01, 40);
        consume(40, "R3 clamp 3->7 100->65");
        load_cfg(1, 7, T7, 65'h1, 11, T11 | 65'h1_F000_0000_0000_0000, 65'h1_0000_0000_0000_0455, 40);
        consume(40, "R3 high bits ignored single");

        // R6: hold off the consumer so the generator stalls at full
        load_cfg(0, 65, T65, 65'h0_DEAD_BEEF_0BAD_F00D, 17, T17, 65'h0_1357, 80);
        repeat (300) @(negedge clk);
        check(ks_valid == 1, "R7 valid when filled", ks_valid, 1);
        consume(80, "R6 stall no loss");

        // R10: reload flushes a full queue
        load_cfg(1, 7, T7, 65'h3, 65, T65, 65'h0_0F0F_0F0F_0F0F_0F0F, 0);
        repeat (60) @(negedge clk);
        load_cfg(0, 11, T11, 65'h7FF, 7, T7, 65'h2B, 30);
        consume(30, "R10 reload restarts");

        // R5: zero data seed
        load_cfg(1, 7, T7, 65'h1, 17, T17, 65'h1_0000_0000_0000_0000, 30);
        check(seed_warn == 1, "R5 zero seed warns", seed_warn, 1);
        consume(30, "R5 zero seed loads 1");
        load_cfg(0, 7, T7, 65'h11, 11, T11, 65'h123, 10);
        check(seed_warn == 1, "R5 warn sticky", seed_warn, 1);
        consume(10, "R1 after warn");

        summary();
        $finish;
    end
endmodule